// File: doc/BRIEF.md
# Emulated EEPROM Access Controller

This block sits on a CPU register bus and lets software read, write and erase a small nonvolatile word store. The store is modelled inside the block as a 32-word by 16-bit array. It is split into four lane banks, one for each position within a 4-word unit, so each bank can map onto block RAM. Software sees six registers: a control register, an address register and four 16-bit data holding registers.

Each operation has an arm bit and a go bit in the control register. A write or an erase starts only when its go bit is written in the clock cycle straight after the write that raised its arm bit. A read starts when its go bit is written while its arm bit is already stored high. Once an operation starts, the block stalls the CPU for a fixed number of cycles, `OP_CYCLES`. At the end of that time it clears the go bit, which software can poll to see that the operation is done.

- An erase zeroes one 16-word page.
- A write stores the four holding registers into one aligned 4-word unit.
- A read fetches one word into the first holding register.

Top module: `ee_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the control, address and four data registers clear to zero and `cpu_stall` goes low. Register selects: 0 is control, 1 is address, 2 to 5 are data holding registers D0 to D3. `bus_rdata` shows the register selected in the previous cycle.
- R2: A write copies D0..D3 into words 4u..4u+3, where u is address bits 4..2. Address bits 1..0 are ignored. Lane k receives Dk.
- R3: An erase sets all 16 words of the page picked by address bit 4 to zero. Address bits 3..0 are ignored and the other page is untouched.
- R4: A read loads the word at the full 5-bit address into D0.
- R5: Control bits are: bit0 read arm, bit1 read go, bit2 write arm, bit3 write go, bit4 erase arm, bit5 erase go. A write or erase starts only if the control write carrying its go bit directly follows a control write that set its arm bit. Otherwise the go bit stays 0, no stall occurs and the array is unchanged.
- R6: A read go bit written while the stored read arm bit is 0 is ignored: no stall occurs and D0 is unchanged.
- R7: `cpu_stall` rises on the edge that accepts a go bit and stays high for exactly `OP_CYCLES` cycles. Bus writes made while it is high are ignored.
- R8: The go bit of a running operation reads back as 1 and clears when the operation completes. Arm bits keep their written value.
- R9: D0 keeps the value fetched by a read until a later read or a bus write to D0 replaces it. Idle cycles and rejected starts leave it unchanged.
- R10: If several go bits are valid in the same write, only one operation runs. Erase wins over write, and write wins over read.
- R11: Reset leaves the array contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 3 | Register select |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Registered read data of the previous cycle's select |
| cpu_stall | output | 1 | High while an operation runs |

## Verification
The bench builds the block with `OP_CYCLES` set to 6. At that value the stall length can be counted exactly, and the bench can poll a go bit and write the bus in the middle of an operation. The value is still above the four cycles an erase needs to clear its page one row per cycle. The default geometry of 32 words in four lanes is kept, so both pages and every unit alignment can be reached directly.

// File: rtl/ee_pkg.sv
package ee_pkg;
  localparam int SEL_W  = 3;
  localparam int CTRL_W = 6;

  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd0;
  localparam logic [SEL_W-1:0] SEL_ADDR = 3'd1;
  localparam logic [SEL_W-1:0] SEL_D0   = 3'd2;

  localparam int CB_RD_ARM = 0;
  localparam int CB_RD_GO  = 1;
  localparam int CB_WR_ARM = 2;
  localparam int CB_WR_GO  = 3;
  localparam int CB_ER_ARM = 4;
  localparam int CB_ER_GO  = 5;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_ERASE = 2'd3
  } op_e;
endpackage

// File: rtl/ee_bank.sv
module ee_bank #(
  parameter int ROW_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ROW_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ROW_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ROW_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ee_seq.sv
module ee_seq
  import ee_pkg::*;
#(
  parameter int OP_CYCLES = 8,
  parameter int CNT_W     = $clog2(OP_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              busy,
  output op_e               op,
  output logic [CNT_W-1:0]  step,
  output logic              done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OP_CYCLES - 1);

  logic [1:0] arm_prev_q;  // {erase, write} arm set by the previous cycle's write
  logic       er_ok, wr_ok, rd_ok;
  op_e        pick;

  always_comb begin
    er_ok = ctrl_wdata[CB_ER_GO] && arm_prev_q[1];
    wr_ok = ctrl_wdata[CB_WR_GO] && arm_prev_q[0];
    rd_ok = ctrl_wdata[CB_RD_GO] && ctrl_q[CB_RD_ARM];
    if (er_ok)      pick = OP_ERASE;
    else if (wr_ok) pick = OP_WRITE;
    else if (rd_ok) pick = OP_READ;
    else            pick = OP_NONE;
    done = busy && (step == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_prev_q <= '0;
      ctrl_q     <= '0;
      busy       <= 1'b0;
      op         <= OP_NONE;
      step       <= '0;
    end else begin
      arm_prev_q <= ctrl_wr ? {ctrl_wdata[CB_ER_ARM], ctrl_wdata[CB_WR_ARM]} : 2'b00;
      if (ctrl_wr) begin
        ctrl_q[CB_RD_ARM] <= ctrl_wdata[CB_RD_ARM];
        ctrl_q[CB_WR_ARM] <= ctrl_wdata[CB_WR_ARM];
        ctrl_q[CB_ER_ARM] <= ctrl_wdata[CB_ER_ARM];
        ctrl_q[CB_RD_GO]  <= (pick == OP_READ);
        ctrl_q[CB_WR_GO]  <= (pick == OP_WRITE);
        ctrl_q[CB_ER_GO]  <= (pick == OP_ERASE);
        if (pick != OP_NONE) begin
          busy <= 1'b1;
          op   <= pick;
          step <= '0;
        end
      end else if (busy) begin
        if (done) begin
          busy              <= 1'b0;
          op                <= OP_NONE;
          ctrl_q[CB_RD_GO]  <= 1'b0;
          ctrl_q[CB_WR_GO]  <= 1'b0;
          ctrl_q[CB_ER_GO]  <= 1'b0;
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end

  assert_one_op_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl_q[CB_ER_GO], ctrl_q[CB_WR_GO], ctrl_q[CB_RD_GO]}));

  assert_go_matches_stall_R8: assert property (@(posedge clk) disable iff (rst)
    busy == (ctrl_q[CB_ER_GO] || ctrl_q[CB_WR_GO] || ctrl_q[CB_RD_GO]));

  assert_late_write_rejected_R5: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && ctrl_wdata[CB_WR_GO] && !arm_prev_q[0]) |=> !ctrl_q[CB_WR_GO]);

  assert_late_erase_rejected_R5: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && ctrl_wdata[CB_ER_GO] && !arm_prev_q[1]) |=> !ctrl_q[CB_ER_GO]);

  assert_stall_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);

  assert_go_clears_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> (!busy && !ctrl_q[CB_WR_GO] && !ctrl_q[CB_ER_GO] && !ctrl_q[CB_RD_GO]));
endmodule

// File: rtl/ee_ctrl.sv
module ee_ctrl
  import ee_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int UNIT_LOG  = 2,
  parameter int PAGE_LOG  = 4,
  parameter int OP_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [SEL_W-1:0]  bus_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cpu_stall
);
  localparam int LANES    = 1 << UNIT_LOG;
  localparam int ROW_W    = ADDR_W - UNIT_LOG;
  localparam int PROW_LOG = PAGE_LOG - UNIT_LOG;
  localparam int CNT_W    = $clog2(OP_CYCLES + 1);
  localparam logic [CNT_W-1:0] PAGE_ROWS = CNT_W'(1 << PROW_LOG);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q [LANES];
  logic [CTRL_W-1:0] ctrl_q;
  logic              busy, done;
  op_e               op;
  logic [CNT_W-1:0]  step;
  logic              ctrl_wr;
  logic              erase_row, write_unit, bank_we;
  logic [ROW_W-1:0]  bank_waddr;
  logic [DATA_W-1:0] bank_wdata [LANES];
  logic [DATA_W-1:0] bank_rdata [LANES];

  assign ctrl_wr   = bus_wr && !busy && (bus_sel == SEL_CTRL);
  assign cpu_stall = busy;

  ee_seq #(.OP_CYCLES(OP_CYCLES), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (bus_wdata[CTRL_W-1:0]),
    .ctrl_q     (ctrl_q),
    .busy       (busy),
    .op         (op),
    .step       (step),
    .done       (done)
  );

  // Erase clears one row of every lane per cycle; a write lands on the last cycle.
  always_comb begin
    erase_row  = busy && (op == OP_ERASE) && (step < PAGE_ROWS);
    write_unit = done && (op == OP_WRITE);
    bank_we    = erase_row || write_unit;
    if (erase_row)
      bank_waddr = {addr_q[ADDR_W-1:PAGE_LOG], step[PROW_LOG-1:0]};
    else
      bank_waddr = addr_q[ADDR_W-1:UNIT_LOG];
  end

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign bank_wdata[b] = erase_row ? '0 : data_q[b];
    ee_bank #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_bank (
      .clk   (clk),
      .we    (bank_we),
      .waddr (bank_waddr),
      .wdata (bank_wdata[b]),
      .raddr (addr_q[ADDR_W-1:UNIT_LOG]),
      .rdata (bank_rdata[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      for (int k = 0; k < LANES; k++) data_q[k] <= '0;
    end else begin
      if (bus_wr && !busy) begin
        if (bus_sel == SEL_ADDR) addr_q <= bus_wdata[ADDR_W-1:0];
        for (int k = 0; k < LANES; k++)
          if (bus_sel == SEL_D0 + SEL_W'(k)) data_q[k] <= bus_wdata;
      end
      if (done && (op == OP_READ))
        data_q[0] <= bank_rdata[addr_q[UNIT_LOG-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      if (bus_sel == SEL_CTRL) bus_rdata <= DATA_W'(ctrl_q);
      if (bus_sel == SEL_ADDR) bus_rdata <= DATA_W'(addr_q);
      for (int k = 0; k < LANES; k++)
        if (bus_sel == SEL_D0 + SEL_W'(k)) bus_rdata <= data_q[k];
    end
  end

  assert_addr_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    cpu_stall |=> $stable(addr_q));

  assert_lane_data_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    cpu_stall |=> $stable(data_q[LANES-1]));

  assert_reset_unstalls_R1: assert property (@(posedge clk)
    rst |=> !cpu_stall);
endmodule

// File: tb/ee_ctrl_tb.sv
module ee_ctrl_tb;
  localparam int OPC = 6;
  localparam logic [2:0] S_CTRL = 3'd0, S_ADDR = 3'd1, S_D0 = 3'd2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_sel = 3'd0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        cpu_stall;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [32];

  always #5 clk = ~clk;

  ee_ctrl #(.OP_CYCLES(OPC)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_stall(cpu_stall)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc_wr(input logic [2:0] sel, input logic [15:0] d);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [15:0] v);
    bus_sel = sel;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (cpu_stall && n < 1000) begin @(negedge clk); n++; end
  endtask

  // Arm, go on the next cycle, count stall, watch the go bit, check it clears.
  task automatic run_op(input logic [15:0] arm, input logic [15:0] go, input string tag);
    int n = 0;
    bit seen = 0;
    logic [15:0] v;
    cyc_wr(S_CTRL, arm);
    cyc_wr(S_CTRL, go);
    check({tag, " R7 stall raised"}, {15'd0, cpu_stall}, 16'd1);
    while (cpu_stall && n < 1000) begin
      bus_sel = S_CTRL;
      @(negedge clk); n++;
      if (cpu_stall && ((bus_rdata & (go & 16'h002A)) != 0)) seen = 1;
    end
    check({tag, " R7 stall length"}, 16'(n), 16'(OPC));
    check({tag, " R8 go seen during op"}, {15'd0, seen}, 16'd1);
    rd(S_CTRL, v);
    check({tag, " R8 go cleared"}, v & 16'h002A, 16'h0000);
  endtask

  task automatic read_word(input logic [4:0] a, input string tag);
    logic [15:0] v;
    cyc_wr(S_ADDR, {11'd0, a});
    run_op(16'h0001, 16'h0003, "read");
    rd(S_D0, v);
    check({tag, " R4 read word"}, v, model[a]);
  endtask

  task automatic write_unit(input logic [4:0] a, input logic [15:0] w0, w1, w2, w3);
    cyc_wr(S_D0, w0); cyc_wr(S_D0 + 3'd1, w1);
    cyc_wr(S_D0 + 3'd2, w2); cyc_wr(S_D0 + 3'd3, w3);
    cyc_wr(S_ADDR, {11'd0, a});
    run_op(16'h0004, 16'h000C, "write");
    model[{a[4:2], 2'd0}] = w0; model[{a[4:2], 2'd1}] = w1;
    model[{a[4:2], 2'd2}] = w2; model[{a[4:2], 2'd3}] = w3;
  endtask

  task automatic erase_page(input logic [4:0] a);
    cyc_wr(S_ADDR, {11'd0, a});
    run_op(16'h0010, 16'h0030, "erase");
    for (int i = 0; i < 16; i++) model[{a[4], 4'(i)}] = 16'h0000;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 stall after reset", {15'd0, cpu_stall}, 16'd0);
    for (int s = 0; s < 6; s++) begin
      rd(3'(s), v);
      check("R1 register cleared", v, 16'h0000);
    end
  endtask

  task automatic t_write_read();
    write_unit(5'h0B, 16'hA001, 16'hA002, 16'hA003, 16'hA004);  // unit 2, low bits ignored
    read_word(5'h08, "R2 lane0");
    read_word(5'h09, "R2 lane1");
    read_word(5'h0B, "R2 lane3");
    read_word(5'h0C, "R2 neighbour untouched");
    write_unit(5'h13, 16'h1111, 16'h2222, 16'h3333, 16'h4444);
    read_word(5'h12, "R2 page1 unit");
  endtask

  task automatic t_erase();
    write_unit(5'h00, 16'h0F0F, 16'hF0F0, 16'h1234, 16'h5678);
    erase_page(5'h07);  // page 0, bits 3..0 nonzero
    read_word(5'h01, "R3 page0 word1");
    read_word(5'h09, "R3 page0 word9");
    read_word(5'h13, "R3 page1 kept");
  endtask

  task automatic t_reject();
    logic [15:0] v;
    cyc_wr(S_D0, 16'hBEEF);
    cyc_wr(S_ADDR, 16'h0010);
    cyc_wr(S_CTRL, 16'h0004);
    @(negedge clk);  // gap: go no longer follows arm
    cyc_wr(S_CTRL, 16'h000C);
    check("R5 late write no stall", {15'd0, cpu_stall}, 16'd0);
    rd(S_CTRL, v);
    check("R5 late write go low", v, 16'h0004);
    cyc_wr(S_CTRL, 16'h0010);
    @(negedge clk);
    cyc_wr(S_CTRL, 16'h0030);
    check("R5 late erase no stall", {15'd0, cpu_stall}, 16'd0);
    read_word(5'h10, "R5 array unchanged");
    read_word(5'h13, "R5 page1 intact");
    rd(S_D0, v);
    cyc_wr(S_CTRL, 16'h0000);
    cyc_wr(S_CTRL, 16'h0003);  // read arm was stored low
    check("R6 read without arm no stall", {15'd0, cpu_stall}, 16'd0);
    rd(S_D0, model[31]);
    check("R6 D0 unchanged", model[31], v);
    model[31] = 16'h0000;
  endtask

  task automatic t_stall_ignore();
    logic [15:0] v;
    cyc_wr(S_D0, 16'h7001); cyc_wr(S_D0 + 3'd1, 16'h7002);
    cyc_wr(S_D0 + 3'd2, 16'h7003); cyc_wr(S_D0 + 3'd3, 16'h7004);
    cyc_wr(S_ADDR, 16'h0004);
    cyc_wr(S_CTRL, 16'h0004);
    cyc_wr(S_CTRL, 16'h000C);
    cyc_wr(S_D0 + 3'd1, 16'hDEAD);
    cyc_wr(S_ADDR, 16'h001F);
    cyc_wr(S_CTRL, 16'h0000);
    wait_idle();
    model[4] = 16'h7001; model[5] = 16'h7002; model[6] = 16'h7003; model[7] = 16'h7004;
    rd(S_D0 + 3'd1, v);
    check("R7 data write ignored during stall", v, 16'h7002);
    rd(S_ADDR, v);
    check("R7 address write ignored during stall", v, 16'h0004);
    rd(S_CTRL, v);
    check("R8 arm bits kept after write", v, 16'h0004);
    read_word(5'h05, "R7 written lane1");
  endtask

  task automatic t_priority();
    logic [15:0] v;
    write_unit(5'h04, 16'h5A5A, 16'h5A5B, 16'h5A5C, 16'h5A5D);
    cyc_wr(S_D0, 16'h9999);
    cyc_wr(S_CTRL, 16'h0014);
    cyc_wr(S_CTRL, 16'h003C);
    wait_idle();
    rd(S_CTRL, v);
    check("R10 only erase ran, go bits clear", v, 16'h0014);
    for (int i = 0; i < 16; i++) model[i] = 16'h0000;
    read_word(5'h04, "R10 erase won over write");
  endtask

  task automatic t_hold();
    logic [15:0] v;
    write_unit(5'h18, 16'hC0DE, 16'hC1DE, 16'hC2DE, 16'hC3DE);
    read_word(5'h1A, "R9 setup");
    repeat (10) @(negedge clk);
    cyc_wr(S_CTRL, 16'h0010);
    @(negedge clk);
    cyc_wr(S_CTRL, 16'h0030);
    rd(S_D0, v);
    check("R9 D0 holds read data", v, 16'hC2DE);
  endtask

  task automatic t_reset_keep();
    logic [15:0] v;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd(S_D0, v);
    check("R1 D0 cleared by reset", v, 16'h0000);
    read_word(5'h1B, "R11 array kept over reset");
    read_word(5'h13, "R11 page1 word kept");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    erase_page(5'h00);
    erase_page(5'h10);
    t_write_read();
    t_erase();
    t_reject();
    t_stall_ignore();
    t_priority();
    t_hold();
    t_reset_keep();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule